// File: doc/BRIEF.md
# Temperature-indexed lookup code selector

This block picks the 8-bit input code for a current-output DAC. Its usual source is a 64-row table, addressed from a debounced temperature reading. Conversion results come from an on-die temperature ADC. A result is only accepted into the 8-bit status register after four back-to-back conversions agree on their upper six bits. A filter-off input lets every conversion through instead. Status value 0x00 is the coldest point of the sensor range and 0xFF is the hottest.

The upper six bits of the status register normally choose the table row. A row-direct select replaces them with a 6-bit override. The row is added to a table base of 0x90, so the byte addresses run from 0x90 to 0xCF. These addresses are presented to a synchronous table memory, and the returned byte is registered as the DAC code. A DAC-direct select bypasses both the ADC and the table and drives the code from an 8-bit override value.

The code stays at 0x00 from reset until the first reading has been accepted. The code register changes only on a clock edge.

Top module: `lut_code_sel`

## Requirements
- R1: After reset, status_o, dac_code_o and tbl_rd_o are all zero.
- R2: With filt_off_i low, status_o loads the full byte of a conversion only when that conversion is the fourth or later in an unbroken run whose bits [7:2] are equal. Otherwise status_o holds.
- R3: A conversion whose bits [7:2] differ from those of the previous conversion restarts the match run at one. It takes three more matching conversions after it before status_o updates.
- R4: With filt_off_i high, every accepted conversion loads status_o on the clock edge that samples it.
- R5: While adc_en_i is low, conversions are ignored and status_o does not change.
- R6: tbl_addr_o is registered and equals 0x90 plus the row. The row is status_o[7:2] when row_dir_sel_i is 0 and row_dir_i when it is 1, so the range is 0x90 to 0xCF.
- R7: With dac_dir_sel_i at 1, dac_code_o equals dac_dir_i one edge later, whatever row_dir_sel_i holds. With dac_dir_sel_i at 0, dac_code_o is the table byte at tbl_addr_o, and it changes on the third edge after the edge that updated status_o.
- R8: dac_code_o stays 0x00 until the first conversion has been accepted, in every select mode.
- R9: A change of either select input changes the output without any new conversion.
- R10: From the edge after the first accepted conversion, tbl_rd_o is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adc_en_i | input | 1 | ADC enabled; conversions are ignored when low |
| conv_valid_i | input | 1 | One-cycle strobe marking a new conversion |
| conv_data_i | input | 8 | Conversion result |
| filt_off_i | input | 1 | 1: accept every conversion without debouncing |
| row_dir_sel_i | input | 1 | 1: table row comes from row_dir_i |
| row_dir_i | input | 6 | Override table row |
| dac_dir_sel_i | input | 1 | 1: DAC code comes from dac_dir_i |
| dac_dir_i | input | 8 | Override DAC code |
| tbl_rd_o | output | 1 | Table read enable |
| tbl_addr_o | output | 8 | Table byte address |
| tbl_data_i | input | 8 | Table read data, one cycle after the read |
| status_o | output | 8 | Accepted temperature reading |
| dac_code_o | output | 8 | Registered DAC input code |

## Verification
The assertions are checked on every cycle for the following properties:
- status stays put when no conversion is sampled;
- a mismatching conversion never updates status while filtering is on;
- the filter-off path loads the sampled byte;
- table addresses stay inside the window;
- reads run continuously once a reading has been accepted;
- the code is zero before acceptance and follows the override in direct mode.

Other behaviour can only be shown by the bench's scenarios:
- how many matching conversions it takes before status updates;
- the restart after a mismatch;
- the exact three-edge latency from a status update to a new table code;
- the table byte that is actually selected after a select bit changes.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ROW_W   = 6;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned MATCH_N = 4;
  localparam logic [ADDR_W-1:0] TBL_BASE = 8'h90;
endpackage

// File: rtl/lcs_filter.sv
module lcs_filter #(
  parameter int unsigned DW      = lcs_pkg::DATA_W,
  parameter int unsigned RW      = lcs_pkg::ROW_W,
  parameter int unsigned MATCH_N = lcs_pkg::MATCH_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adc_en_i,
  input  logic          conv_valid_i,
  input  logic [DW-1:0] conv_data_i,
  input  logic          filt_off_i,
  output logic [DW-1:0] status_o,
  output logic          acc_o
);
  localparam int unsigned CW = $clog2(MATCH_N + 1);

  logic [RW-1:0] prev_top_q;
  logic          prev_vld_q;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [DW-1:0] status_q;
  logic          acc_q;
  logic          take, same, accept;
  logic [RW-1:0] top;

  assign take = conv_valid_i & adc_en_i;
  assign top  = conv_data_i[DW-1 -: RW];
  assign same = prev_vld_q && (top == prev_top_q);

  // run length saturates at the match target
  always_comb begin
    if (!same)                    cnt_nxt = CW'(1);
    else if (cnt_q == CW'(MATCH_N)) cnt_nxt = cnt_q;
    else                          cnt_nxt = cnt_q + CW'(1);
  end

  assign accept = take && (filt_off_i || cnt_nxt == CW'(MATCH_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_top_q <= '0;
      prev_vld_q <= 1'b0;
      cnt_q      <= '0;
      status_q   <= '0;
      acc_q      <= 1'b0;
    end else if (take) begin
      prev_top_q <= top;
      prev_vld_q <= 1'b1;
      cnt_q      <= cnt_nxt;
      if (accept) begin
        status_q <= conv_data_i;
        acc_q    <= 1'b1;
      end
    end
  end

  assign status_o = status_q;
  assign acc_o    = acc_q;

  // R5
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take |=> $stable(status_q));
  // R4
  filt_off_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && filt_off_i |=> status_q == $past(conv_data_i));
  // R3
  mismatch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !filt_off_i && prev_vld_q && (top != prev_top_q) && (MATCH_N > 1)
    |=> $stable(status_q));
endmodule

// File: rtl/lcs_row_addr.sv
module lcs_row_addr #(
  parameter int unsigned DW = lcs_pkg::DATA_W,
  parameter int unsigned RW = lcs_pkg::ROW_W,
  parameter int unsigned AW = lcs_pkg::ADDR_W,
  parameter logic [AW-1:0] BASE = lcs_pkg::TBL_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] status_i,
  input  logic          acc_i,
  input  logic          row_dir_sel_i,
  input  logic [RW-1:0] row_dir_i,
  output logic          rd_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned ROWS = 1 << RW;

  logic [RW-1:0] row;
  logic [AW-1:0] addr_q;
  logic          rd_q;

  assign row = row_dir_sel_i ? row_dir_i : status_i[DW-1 -: RW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= BASE;
      rd_q   <= 1'b0;
    end else begin
      addr_q <= BASE + AW'(row);
      rd_q   <= acc_i;
    end
  end

  assign rd_o   = rd_q;
  assign addr_o = addr_q;

  // R6
  addr_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_q |-> (addr_q >= BASE) && (addr_q <= BASE + AW'(ROWS - 1)));
  // R10
  rd_cont_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> rd_q);
endmodule

// File: rtl/lcs_code_reg.sv
module lcs_code_reg #(
  parameter int unsigned DW = lcs_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          rd_i,
  input  logic          dac_dir_sel_i,
  input  logic [DW-1:0] dac_dir_i,
  input  logic [DW-1:0] tbl_data_i,
  output logic [DW-1:0] code_o
);
  logic          rvld_q;
  logic [DW-1:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvld_q <= 1'b0;
      code_q <= '0;
    end else begin
      rvld_q <= rd_i;
      if (dac_dir_sel_i)  code_q <= acc_i ? dac_dir_i : '0;
      else if (rvld_q)    code_q <= tbl_data_i;
    end
  end

  assign code_o = code_q;

  // R8
  zero_before_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |-> code_q == '0);
  // R7
  dac_direct_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i && dac_dir_sel_i |=> code_q == $past(dac_dir_i));
endmodule

// File: rtl/lut_code_sel.sv
module lut_code_sel #(
  parameter int unsigned DW      = lcs_pkg::DATA_W,
  parameter int unsigned RW      = lcs_pkg::ROW_W,
  parameter int unsigned AW      = lcs_pkg::ADDR_W,
  parameter int unsigned MATCH_N = lcs_pkg::MATCH_N,
  parameter logic [AW-1:0] BASE  = lcs_pkg::TBL_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adc_en_i,
  input  logic          conv_valid_i,
  input  logic [DW-1:0] conv_data_i,
  input  logic          filt_off_i,
  input  logic          row_dir_sel_i,
  input  logic [RW-1:0] row_dir_i,
  input  logic          dac_dir_sel_i,
  input  logic [DW-1:0] dac_dir_i,
  output logic          tbl_rd_o,
  output logic [AW-1:0] tbl_addr_o,
  input  logic [DW-1:0] tbl_data_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] dac_code_o
);
  logic [DW-1:0] status;
  logic          acc;
  logic          rd;

  lcs_filter #(.DW(DW), .RW(RW), .MATCH_N(MATCH_N)) u_filter (
    .clk_i, .rst_ni, .adc_en_i, .conv_valid_i, .conv_data_i, .filt_off_i,
    .status_o(status), .acc_o(acc)
  );

  lcs_row_addr #(.DW(DW), .RW(RW), .AW(AW), .BASE(BASE)) u_row (
    .clk_i, .rst_ni, .status_i(status), .acc_i(acc),
    .row_dir_sel_i, .row_dir_i, .rd_o(rd), .addr_o(tbl_addr_o)
  );

  lcs_code_reg #(.DW(DW)) u_code (
    .clk_i, .rst_ni, .acc_i(acc), .rd_i(rd), .dac_dir_sel_i, .dac_dir_i,
    .tbl_data_i, .code_o(dac_code_o)
  );

  assign status_o = status;
  assign tbl_rd_o = rd;
endmodule

// File: tb/tb_lut_code_sel.sv
module tb_lut_code_sel;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] data;
    logic       foff;
    logic [7:0] exp_st;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{8'h40, 1'b0, 8'h00}, '{8'h41, 1'b0, 8'h00}, '{8'h42, 1'b0, 8'h00},
    '{8'h43, 1'b0, 8'h43}, '{8'h44, 1'b0, 8'h43}, '{8'h45, 1'b0, 8'h43},
    '{8'h80, 1'b0, 8'h43}, '{8'h81, 1'b0, 8'h43}, '{8'h82, 1'b0, 8'h43},
    '{8'h83, 1'b0, 8'h83}, '{8'h10, 1'b1, 8'h10}, '{8'hFF, 1'b1, 8'hFF}
  };

  logic clk = 0, rst_ni = 0;
  logic adc_en = 0, conv_valid = 0, filt_off = 0, row_sel = 0, dac_sel = 0;
  logic [7:0] conv_data = 0, dac_dir = 0, tbl_addr, tbl_data = 0, status, code;
  logic [5:0] row_dir = 0;
  logic tbl_rd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lut_code_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .adc_en_i(adc_en), .conv_valid_i(conv_valid),
    .conv_data_i(conv_data), .filt_off_i(filt_off), .row_dir_sel_i(row_sel),
    .row_dir_i(row_dir), .dac_dir_sel_i(dac_sel), .dac_dir_i(dac_dir),
    .tbl_rd_o(tbl_rd), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
    .status_o(status), .dac_code_o(code)
  );

  function automatic logic [7:0] tbl(input logic [7:0] a);
    logic [7:0] i = a - 8'h90;
    return 8'((int'(i) * 37 + 11) & 255);
  endfunction

  always_ff @(posedge clk) if (tbl_rd) tbl_data <= tbl(tbl_addr);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input logic [7:0] d);
    @(negedge clk); conv_valid = 1; conv_data = d;
    @(negedge clk); conv_valid = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    chk("R1 status", status, 8'h00);
    chk("R1 code", code, 8'h00);
    chk("R1 rd", {7'b0, tbl_rd}, 8'h00);
    rst_ni = 1;
    // R5: ADC disabled, filter off
    filt_off = 1;
    conv(8'h77);
    chk("R5 status", status, 8'h00);
    // R8: direct DAC before any acceptance
    dac_sel = 1; dac_dir = 8'h5A;
    wait_n(2);
    chk("R8 code", code, 8'h00);
    chk("R10 rd before accept", {7'b0, tbl_rd}, 8'h00);
    dac_sel = 0; filt_off = 0; adc_en = 1;
    // R2/R3/R4 vector walk
    for (int i = 0; i < NV; i++) begin
      filt_off = VECS[i].foff;
      conv(VECS[i].data);
      chk($sformatf("R2/R3/R4 vec %0d", i), status, VECS[i].exp_st);
    end
    chk("R10 rd", {7'b0, tbl_rd}, 8'h01);
    // R6: row from status 0xFF -> 0xCF
    wait_n(4);
    chk("R6 addr top", tbl_addr, 8'hCF);
    chk("R7 table code", code, tbl(8'hCF));
    // R9/R6: row override without conversion
    row_sel = 1; row_dir = 6'd5;
    wait_n(4);
    chk("R9 row addr", tbl_addr, 8'h95);
    chk("R9 row code", code, tbl(8'h95));
    // R7: DAC override wins over row select
    @(negedge clk); dac_sel = 1; dac_dir = 8'hA5;
    @(negedge clk);
    chk("R7 direct", code, 8'hA5);
    row_sel = 0;
    wait_n(2);
    chk("R7 direct ignores row", code, 8'hA5);
    // R9: back to table
    dac_sel = 0;
    wait_n(4);
    chk("R9 back to table", code, tbl(8'hCF));
    // R7 latency: status edge then three edges
    filt_off = 1;
    conv(8'h20);
    chk("R4 status", status, 8'h20);
    wait_n(2);
    chk("R7 latency hold", code, tbl(8'hCF));
    wait_n(1);
    chk("R7 latency new", code, tbl(8'h98));
    // R5 after acceptance
    adc_en = 0;
    conv(8'hEE);
    chk("R5 ignored", status, 8'h20);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule